// File: doc/BRIEF.md
# Receive FIFO Burst Writer

This block drains read data from an internal staging buffer into a user receive FIFO, one 512-byte burst (eight 512-bit words) at a time. A source stream, standing in for data returning from a storage device, fills the staging buffer. Once the user programs a transfer length in 512-byte blocks and pulses start, the block writes exactly that many bursts into the FIFO. Nothing moves unless the FIFO has coarse headroom and the staging buffer already holds a whole burst.

The FIFO reports its fill as a 16-bit write count. A FIFO with a narrower count pads the unused upper bits with ones, so a shallow FIFO that is nearly full reads as nearly full here too. Headroom is judged on the upper bits only. A burst may start when bits [15:4] are not all ones. A burst may follow another without a gap only when bits [15:5] are not all ones and the staging buffer holds at least two bursts. A parameter sets the staging buffer to a small depth or to a high-speed depth four times larger.

Top module: `rxbw_burst_writer`

## Requirements
- R1: While busy and not bursting, a burst starts only when `fifo_wr_cnt[15:4]` is not all ones and `buf_level` is at least 8. A count whose upper bits are padded with ones (for example 16'hFFF0) therefore holds the writer off, and so does a staging buffer holding fewer than 8 words.
- R2: Every burst asserts `fifo_wr_en` for a whole multiple of 8 consecutive cycles. `fifo_wr_data` is valid on those same cycles.
- R3: On the last word of a burst, when more bursts remain, the next burst follows with no idle cycle only if `fifo_wr_cnt[15:5]` is not all ones and `buf_level` is at least 16 in that cycle.
- R4: When the R3 condition fails, `fifo_wr_en` is low for at least one cycle and the R1 condition is evaluated again.
- R5: Words reach the FIFO in the order they were accepted from the source, with no word dropped or duplicated across burst boundaries.
- R6: A transfer of N blocks writes exactly 8*N words. `done` is high for exactly one cycle, the cycle after the final write, and `busy` is low from that cycle on. If the source supplied exactly 8*N words, `buf_level` is then 0.
- R7: `src_ready` is low exactly when the staging buffer is full. A word is accepted on a cycle with `src_valid` and `src_ready` both high. `buf_level` tracks pushes and pops one for one.
- R8: With `BIG_MODE`=0 the staging buffer holds 32 words. With `BIG_MODE`=1 it holds 128 words.
- R9: A start with length 0 writes nothing and gives the `done` pulse one cycle after the start.
- R10: A start pulse while `busy` is high is ignored and does not change the length of the transfer in progress.
- R11: After reset, `fifo_wr_en`, `busy` and `done` are low, `buf_level` is 0 and `src_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transfer; sampled only while idle |
| len_blk | input | LEN_W | Transfer length in 512-byte blocks |
| src_valid | input | 1 | Source word present |
| src_data | input | DATA_W | Source word |
| src_ready | output | 1 | Staging buffer can accept a word |
| fifo_wr_cnt | input | 16 | Receive FIFO fill count, unused upper bits tied to one |
| fifo_wr_en | output | 1 | Receive FIFO write strobe |
| fifo_wr_data | output | DATA_W | Receive FIFO write word |
| buf_level | output | LVL_W | Words held in the staging buffer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the transfer has completed |

## Verification
The bench preloads a full small buffer and runs four blocks with an empty FIFO. It expects runs of exactly 24 and 8 words: the chain decision runs out of staging data at the third burst. A writer that tested the level at the wrong beat would give different run lengths. A count of 16'hFFE0 permits single bursts but forbids chaining, so four bursts of eight with gaps are expected; a writer that chained on single-burst headroom would merge them. A padded-full count of 16'hFFF0, and a buffer holding only four words, must each hold the writer off completely. A start pulse issued during that stall must not lengthen the transfer, and a zero-length start must finish at once. A writer that ignored the padded bits, started on a partial burst, or reloaded its length would write words it should not.

// File: rtl/rxbw_pkg.sv
package rxbw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } wr_state_e;

  // Coarse headroom: true when cnt[15:lsb] is not all ones.
  function automatic logic fifo_headroom(input logic [15:0] cnt, input int unsigned lsb);
    logic [15:0] low_mask;
    low_mask = (16'(1) << lsb) - 16'(1);
    return (cnt | low_mask) != 16'hFFFF;
  endfunction

  // Staging occupancy: true when at least 'words' are present.
  function automatic logic stage_has(input int unsigned lvl, input int unsigned words);
    return lvl >= words;
  endfunction

endpackage

// File: rtl/rxbw_stage_buf.sv
module rxbw_stage_buf #(
  parameter int DATA_W = 512,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [LVL_W-1:0]  level,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
  assign full      = (level == LVL_W'(DEPTH));

  // R7: occupancy follows pushes and pops one for one
  a_r7_level_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> level == $past(level) + LVL_W'(1));
  a_r7_level_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> level == $past(level) - LVL_W'(1));
  // R5: never read a word that is not there
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level != '0);

endmodule

// File: rtl/rxbw_burst_ctrl.sv
module rxbw_burst_ctrl
  import rxbw_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int LVL_W       = 6,
  parameter int BURST_WORDS = 8,
  localparam int BEAT_W     = $clog2(BURST_WORDS),
  localparam int GRAN_LSB   = $clog2(BURST_WORDS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_blk,
  input  logic [15:0]      fifo_wr_cnt,
  input  logic [LVL_W-1:0] level,
  output logic             wr_en,
  output logic             busy,
  output logic             done
);

  wr_state_e         state;
  logic [BEAT_W-1:0] beat;
  logic [LEN_W-1:0]  rem_blk;
  logic              done_q;

  logic go_ok;
  logic chain_ok;
  logic last_beat;
  logic final_beat;

  assign go_ok      = fifo_headroom(fifo_wr_cnt, GRAN_LSB) &&
                      stage_has(32'(level), BURST_WORDS);
  assign chain_ok   = fifo_headroom(fifo_wr_cnt, GRAN_LSB + 1) &&
                      stage_has(32'(level), 2 * BURST_WORDS);
  assign last_beat  = (state == ST_BURST) && (beat == BEAT_W'(BURST_WORDS - 1));
  assign final_beat = last_beat && (rem_blk == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      beat    <= '0;
      rem_blk <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (len_blk == '0) begin
              done_q <= 1'b1;
            end else begin
              rem_blk <= len_blk;
              state   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (go_ok) begin
            state <= ST_BURST;
            beat  <= '0;
          end
        end
        ST_BURST: begin
          beat <= beat + BEAT_W'(1);
          if (last_beat) begin
            rem_blk <= rem_blk - LEN_W'(1);
            if (final_beat) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else if (!chain_ok) begin
              state <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_en = (state == ST_BURST);
  assign busy  = (state != ST_IDLE);
  assign done  = done_q;

  // Checker-side run counter for whole-burst checking
  logic [BEAT_W-1:0] run_mod;
  always_ff @(posedge clk) begin
    if (!rst_n)     run_mod <= '0;
    else if (wr_en) run_mod <= run_mod + BEAT_W'(1);
  end

  // R1: a burst rises only after the start condition held at the port
  a_r1_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(~&fifo_wr_cnt[15:4] && (32'(level) >= BURST_WORDS)));
  // R2: write enable only falls on a burst boundary
  a_r2_whole_bursts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> run_mod == '0);
  // R3, R4: without double headroom the write enable must drop
  a_r4_chain_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !(~&fifo_wr_cnt[15:5] && (32'(level) >= 2 * BURST_WORDS))) |=> !wr_en);
  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6, R9: done follows either the last write or a zero-length start
  a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) || $past(start)));
  // R10: a start while busy leaves the remaining count alone
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en && !done) |=> rem_blk == $past(rem_blk));

endmodule

// File: rtl/rxbw_burst_writer.sv
module rxbw_burst_writer
  import rxbw_pkg::*;
#(
  parameter int DATA_W      = 512,
  parameter int LEN_W       = 16,
  parameter bit BIG_MODE    = 1'b0,
  parameter int SMALL_WORDS = 32,
  parameter int BURST_WORDS = 8,
  localparam int DEPTH      = BIG_MODE ? 4 * SMALL_WORDS : SMALL_WORDS,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_blk,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic [15:0]       fifo_wr_cnt,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic [LVL_W-1:0]  buf_level,
  output logic              busy,
  output logic              done
);

  logic stage_full;
  logic stage_push;
  logic stage_pop;

  assign src_ready  = !stage_full;
  assign stage_push = src_valid && src_ready;
  assign stage_pop  = fifo_wr_en;

  rxbw_stage_buf #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stage_push),
    .push_data (src_data),
    .pop       (stage_pop),
    .head_data (fifo_wr_data),
    .level     (buf_level),
    .full      (stage_full)
  );

  rxbw_burst_ctrl #(
    .LEN_W       (LEN_W),
    .LVL_W       (LVL_W),
    .BURST_WORDS (BURST_WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .len_blk     (len_blk),
    .fifo_wr_cnt (fifo_wr_cnt),
    .level       (buf_level),
    .wr_en       (fifo_wr_en),
    .busy        (busy),
    .done        (done)
  );

  // R7: a full buffer refuses the source
  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_level == LVL_W'(DEPTH)) |-> !src_ready);

endmodule

// File: tb/rxbw_burst_writer_tb.sv
module rxbw_burst_writer_tb;

  localparam int DATA_W = 512;
  localparam int LEN_W  = 16;
  localparam int SLVL_W = 6;
  localparam int BLVL_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  len_blk = '0;
  logic              src_valid = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  logic              src_ready;
  logic [15:0]       fifo_wr_cnt = 16'h0000;
  logic              fifo_wr_en;
  logic [DATA_W-1:0] fifo_wr_data;
  logic [SLVL_W-1:0] buf_level;
  logic              busy;
  logic              done;

  rxbw_burst_writer #(.DATA_W(DATA_W), .LEN_W(LEN_W), .BIG_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .len_blk(len_blk),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .fifo_wr_cnt(fifo_wr_cnt), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .buf_level(buf_level), .busy(busy), .done(done));

  // Large-mode instance, used only to measure its depth (R8)
  logic              big_valid = 1'b0;
  logic              big_ready;
  logic              big_wr_en;
  logic [DATA_W-1:0] big_wr_data;
  logic [BLVL_W-1:0] big_level;
  logic              big_busy;
  logic              big_done;

  rxbw_burst_writer #(.DATA_W(DATA_W), .LEN_W(LEN_W), .BIG_MODE(1'b1)) u_big (
    .clk(clk), .rst_n(rst_n), .start(1'b0), .len_blk('0),
    .src_valid(big_valid), .src_data('0), .src_ready(big_ready),
    .fifo_wr_cnt(16'hFFFF), .fifo_wr_en(big_wr_en), .fifo_wr_data(big_wr_data),
    .buf_level(big_level), .busy(big_busy), .done(big_done));

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;
  int  cycles = 0;

  // Vector table: {length in blocks, fifo write count}
  localparam logic [31:0] VEC [5] = '{
    {16'd1, 16'h0000},
    {16'd6, 16'h0000},
    {16'd3, 16'hFFE0},
    {16'd5, 16'h1234},
    {16'd4, 16'hFFDF}
  };

  // Monitor state
  int feed_seq = 0;
  int exp_seq  = 0;
  int word_cnt = 0;
  int bad_order = 0;
  int bad_run = 0;
  int run = 0;
  int nruns = 0;
  int max_run = 0;
  int done_cnt = 0;
  int run_log [8];

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL R6 watchdog expired actual=%0d expected=done", cycles);
      finish_up();
    end
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (fifo_wr_en) begin
      if (fifo_wr_data != DATA_W'(exp_seq)) bad_order++;
      exp_seq++;
      word_cnt++;
      run++;
    end else if (run != 0) begin
      if (run % 8 != 0) bad_run++;
      if (nruns < 8) run_log[nruns] = run;
      if (run > max_run) max_run = run;
      nruns++;
      run = 0;
    end
  end

  task automatic clear_stats();
    word_cnt = 0; bad_order = 0; bad_run = 0; nruns = 0; max_run = 0; done_cnt = 0;
    for (int i = 0; i < 8; i++) run_log[i] = 0;
  endtask

  task automatic feed(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (src_ready) begin
        src_valid = 1'b1;
        src_data  = DATA_W'(feed_seq);
        feed_seq++;
        k++;
      end else begin
        src_valid = 1'b0;
      end
    end
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk);
    start = 1'b1;
    len_blk = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic common_checks(input int n);
    check("R6 word count", word_cnt == 8 * n, word_cnt, 8 * n);
    check("R5 order", bad_order == 0, bad_order, 0);
    check("R2 whole bursts", bad_run == 0, bad_run, 0);
    check("R6 single done", done_cnt == 1, done_cnt, 1);
    check("R6 buffer empty", buf_level == 0, buf_level, 0);
    check("R6 busy low", busy == 1'b0, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    check("R11 wr_en", fifo_wr_en == 1'b0, fifo_wr_en, 0);
    check("R11 busy", busy == 1'b0, busy, 0);
    check("R11 done", done == 1'b0, done, 0);
    check("R11 level", buf_level == 0, buf_level, 0);
    check("R11 ready", src_ready == 1'b1, src_ready, 1);

    // Table walk
    for (int v = 0; v < 5; v++) begin
      int n;
      n = int'(VEC[v][31:16]);
      clear_stats();
      fifo_wr_cnt = VEC[v][15:0];
      fork
        feed(8 * n);
        begin pulse_start(n); wait_done(); end
      join
      common_checks(n);
      if (VEC[v][15:0] == 16'hFFE0)
        check("R4 no chaining at single headroom", max_run == 8, max_run, 8);
    end

    // R9: zero-length start
    clear_stats();
    @(negedge clk);
    start = 1'b1; len_blk = '0;
    @(negedge clk);
    start = 1'b0;
    check("R9 done after zero length", done == 1'b1, done, 1);
    check("R9 not busy", busy == 1'b0, busy, 0);
    @(negedge clk);
    check("R9 no writes", word_cnt == 0, word_cnt, 0);

    // R3, R7, R8: preload a full small buffer, then chain
    clear_stats();
    fifo_wr_cnt = 16'h0000;
    feed(32);
    check("R8 small depth", buf_level == 32, buf_level, 32);
    check("R7 ready low when full", src_ready == 1'b0, src_ready, 0);
    pulse_start(4);
    wait_done();
    common_checks(4);
    check("R3 chained run", run_log[0] == 24, run_log[0], 24);
    check("R4 run after gap", run_log[1] == 8, run_log[1], 8);
    check("R4 run count", nruns == 2, nruns, 2);

    // R4: single-burst headroom only, preloaded
    clear_stats();
    fifo_wr_cnt = 16'hFFE0;
    feed(32);
    pulse_start(4);
    wait_done();
    common_checks(4);
    check("R4 separate bursts", nruns == 4, nruns, 4);

    // R1, R10: padded-full count holds the writer off; busy start ignored
    clear_stats();
    fifo_wr_cnt = 16'hFFF0;
    feed(16);
    pulse_start(2);
    repeat (40) @(negedge clk);
    check("R1 padded count blocks", word_cnt == 0, word_cnt, 0);
    check("R1 still busy", busy == 1'b1, busy, 1);
    pulse_start(7);
    fifo_wr_cnt = 16'h0000;
    wait_done();
    check("R10 length kept", word_cnt == 16, word_cnt, 16);
    check("R10 order", bad_order == 0, bad_order, 0);

    // R1: fewer than 8 staged words holds the writer off
    clear_stats();
    feed(4);
    pulse_start(1);
    repeat (20) @(negedge clk);
    check("R1 partial burst blocks", word_cnt == 0, word_cnt, 0);
    feed(4);
    wait_done();
    common_checks(1);

    // R8: large mode depth
    big_valid = 1'b1;
    repeat (140) @(negedge clk);
    check("R8 large depth", big_level == 128, big_level, 128);
    check("R7 large ready low", big_ready == 1'b0, big_ready, 0);
    big_valid = 1'b0;

    finish_up();
  end

endmodule